// File: doc/BRIEF.md
# Timer Input Capture Unit

This block stamps transitions on an external capture pin with the value of a free-running timer count supplied from outside. The pin is asynchronous to the block clock. It first passes through a two-flop synchronizer. An optional digital filter follows, and then an edge detector. When the selected edge arrives, the detector latches the current count into a capture register and sets a capture flag. The flag can raise an interrupt request.

Software controls the unit through a small control register with three live fields: filter enable, edge polarity and interrupt enable. The remaining bits of that register are reserved. They read as zero, and writes to them are ignored. A separate input from the waveform-mode logic tells the unit that the capture register is currently serving as the counter's TOP value. While that input is high, the pin is disconnected from capture. Software clears the flag by writing one to a clear strobe.

Top module: `cap_unit`

## Requirements
- R1: With the filter enabled, the filtered pin level changes only after four successive synchronized samples that agree with each other and differ from the current level. A high pulse of three clock cycles is therefore ignored, and a pulse of four cycles is accepted.
- R2: Without the filter, the flag is visible 4 clock cycles after the pin change. That is, it is seen at the 4th falling clock edge after a pin change driven at a falling edge. With the filter enabled, the same edge is seen exactly four cycles later, at the 8th falling edge.
- R3: Control bit 1 selects the edge. A value of 0 captures on falling edges only, and a value of 1 captures on rising edges only.
- R4: On a qualifying edge, `cap_reg` takes the `count_val` present in the clock cycle in which the capture happens.
- R5: A capture sets `cap_flag`. A one-cycle `flag_clr` clears it. When a capture and a clear fall in the same cycle, the flag stays set.
- R6: `cap_irq` is high exactly when `cap_flag` is set and control bit 2 (interrupt enable) is 1.
- R7: While `top_is_cap` is high, no edge captures: `cap_reg` and `cap_flag` do not change because of the pin.
- R8: The control register holds bit 0 (filter enable), bit 1 (edge select) and bit 2 (interrupt enable). Bits 7 to 3 always read as zero, and writing ones to them has no effect.
- R9: Changing the edge-select bit while the pin is steady produces no capture.
- R10: After reset, `cap_reg`, `cap_flag`, `cap_irq` and the control readback are all zero, and the filter output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous external capture pin |
| count_val | input | 16 | Current timer count |
| top_is_cap | input | 1 | Capture register used as TOP; disables capture |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register readback |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| cap_reg | output | 16 | Captured count |
| cap_flag | output | 1 | Capture flag |
| cap_irq | output | 1 | Capture interrupt request |

## Verification
The bench builds the unit with its default parameters: a 16-bit count, two synchronizer stages and a filter length of four. With those values, the exact unfiltered and filtered latencies can be observed directly, as can the boundary between a three-cycle glitch and a four-cycle pulse. Because the count width is 16, a free-running stimulus counter exercises every captured bit. A behavioural model tracks synchronized samples in a queue and compares all outputs on every clock. On top of that model, directed sequences cover polarity changes, the TOP disable and a clear that collides with a capture.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int CTL_W     = 8;
  localparam int CTL_FILT  = 0;
  localparam int CTL_RISE  = 1;
  localparam int CTL_IRQ   = 2;
  localparam int CTL_LIVE  = 3;

  typedef struct packed {
    logic irq_en;
    logic rise_sel;
    logic filt_en;
  } cap_ctl_t;

  function automatic logic [CTL_W-1:0] ctl_pack(cap_ctl_t c);
    logic [CTL_W-1:0] v;
    v           = '0;
    v[CTL_FILT] = c.filt_en;
    v[CTL_RISE] = c.rise_sel;
    v[CTL_IRQ]  = c.irq_en;
    return v;
  endfunction

  function automatic cap_ctl_t ctl_unpack(logic [CTL_W-1:0] v);
    cap_ctl_t c;
    c.filt_en  = v[CTL_FILT];
    c.rise_sel = v[CTL_RISE];
    c.irq_en   = v[CTL_IRQ];
    return c;
  endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = din;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[LAST];
endmodule

// File: rtl/cap_filter.sv
module cap_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic filt_en,
  input  logic din,
  output logic dout
);
  logic [LEN-1:0] hist_q, hist_d;
  logic           out_q, out_d;
  logic           all_hi, all_lo;

  assign all_hi = &hist_q;
  assign all_lo = ~|hist_q;

  always_comb begin
    hist_d = {hist_q[LEN-2:0], din};
    out_d  = out_q;
    if (!filt_en)                 out_d = din;
    else if (all_hi && !out_q)    out_d = 1'b1;
    else if (all_lo && out_q)     out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      out_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      out_q  <= out_d;
    end
  end

  assign dout = out_q;

  // R1: filtered output never moves while the newest sample disagrees with the new level
  p_filt_agree_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && (out_d != out_q)) |=> (out_q == hist_q[1]));
endmodule

// File: rtl/cap_edge.sv
module cap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  input  logic rise_sel,
  input  logic block,
  output logic cap_event
);
  logic prev_q;
  logic hit_rise, hit_fall, hit;

  assign hit_rise = smp & ~prev_q;
  assign hit_fall = ~smp & prev_q;
  assign hit      = rise_sel ? hit_rise : hit_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= smp;
  end

  assign cap_event = hit & ~block;

  // R3: a capture only follows a level change of the sampled input
  p_edge_needs_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event |-> (smp != prev_q));
endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import cap_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SYNC_N   = 2,
  parameter int FILT_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_pin,
  input  logic [CNT_W-1:0] count_val,
  input  logic             top_is_cap,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap_reg,
  output logic             cap_flag,
  output logic             cap_irq
);
  cap_ctl_t         ctl_q, ctl_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             flag_q, flag_d;
  logic             pin_sync, pin_filt, cap_event;

  cap_sync #(.STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cap_pin),
    .dout (pin_sync)
  );

  cap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .filt_en(ctl_q.filt_en),
    .din    (pin_sync),
    .dout   (pin_filt)
  );

  cap_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp      (pin_filt),
    .rise_sel (ctl_q.rise_sel),
    .block    (top_is_cap),
    .cap_event(cap_event)
  );

  always_comb begin
    ctl_d  = ctl_we ? ctl_unpack(ctl_wdata) : ctl_q;
    cap_d  = cap_event ? count_val : cap_q;
    flag_d = flag_q;
    if (cap_event)     flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      cap_q  <= cap_d;
      flag_q <= flag_d;
    end
  end

  assign ctl_rdata = ctl_pack(ctl_q);
  assign cap_reg   = cap_q;
  assign cap_flag  = flag_q;
  assign cap_irq   = flag_q & ctl_q.irq_en;

  p_cap_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event |=> (cap_reg == $past(count_val)));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event |=> cap_flag);

  p_flag_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_event) |=> !cap_flag);

  p_top_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (top_is_cap && !cap_flag) |=> (!cap_flag && $stable(cap_reg)));

  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_rdata[CTL_W-1:CTL_LIVE] == '0));
endmodule

// File: tb/cap_unit_tb.sv
module cap_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_pin = 1'b0;
  logic [15:0] count_val = 16'h0;
  logic        top_is_cap = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = 8'h0;
  logic [7:0]  ctl_rdata;
  logic        flag_clr = 1'b0;
  logic [15:0] cap_reg;
  logic        cap_flag;
  logic        cap_irq;

  int checks = 0;
  int errors = 0;

  cap_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .count_val(count_val),
    .top_is_cap(top_is_cap), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .flag_clr(flag_clr), .cap_reg(cap_reg),
    .cap_flag(cap_flag), .cap_irq(cap_irq)
  );

  always #5 clk = ~clk;

  always @(negedge clk) count_val <= count_val + 16'd3;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int m_p1, m_p2, m_fo, m_fp, m_flag, m_cap;
  int m_filt, m_rise, m_irq;
  int sq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 = 0; m_p2 = 0; m_fo = 0; m_fp = 0; m_flag = 0; m_cap = 0;
      m_filt = 0; m_rise = 0; m_irq = 0;
      sq = '{0, 0, 0, 0};
    end else begin
      int ev, nfo, hi, lo;
      ev = m_rise ? (m_fo == 1 && m_fp == 0) : (m_fo == 0 && m_fp == 1);
      if (ev && !top_is_cap) begin
        m_cap = count_val; m_flag = 1;
      end else if (flag_clr) m_flag = 0;
      hi = 1; lo = 1;
      foreach (sq[i]) begin
        if (sq[i] != 1) hi = 0;
        if (sq[i] != 0) lo = 0;
      end
      if (!m_filt) nfo = m_p2;
      else if (hi && m_fo == 0) nfo = 1;
      else if (lo && m_fo == 1) nfo = 0;
      else nfo = m_fo;
      m_fp = m_fo; m_fo = nfo;
      sq.push_front(m_p2); void'(sq.pop_back());
      m_p2 = m_p1; m_p1 = cap_pin;
      if (ctl_we) begin
        m_filt = ctl_wdata[0]; m_rise = ctl_wdata[1]; m_irq = ctl_wdata[2];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 model cap_reg", cap_reg, m_cap);
      chk("R5 model cap_flag", cap_flag, m_flag);
      chk("R6 model cap_irq", cap_irq, (m_flag && m_irq) ? 1 : 0);
      chk("R8 model ctl_rdata", ctl_rdata, m_filt | (m_rise << 1) | (m_irq << 2));
    end
  end

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic clr_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic wait_flag(output int n);
    n = 0;
    while (!cap_flag && n < 20) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset cap_reg", cap_reg, 0);
    chk("R10 reset cap_flag", cap_flag, 0);
    chk("R10 reset cap_irq", cap_irq, 0);
    chk("R10 reset ctl_rdata", ctl_rdata, 0);

    wr_ctl(8'hFF);
    chk("R8 reserved bits read zero", ctl_rdata, 8'h07);
    wr_ctl(8'h02);

    // R2 and R4: unfiltered rising capture
    @(negedge clk); cap_pin = 1'b1;
    wait_flag(n);
    chk("R2 unfiltered latency", n, 4);
    chk("R4 captured count", cap_reg, count_val);
    clr_flag();
    chk("R5 flag cleared", cap_flag, 0);

    // R2 filtered
    wr_ctl(8'h03);
    @(negedge clk); cap_pin = 1'b0;
    idle(12);
    chk("R3 falling ignored in rising mode", cap_flag, 0);
    @(negedge clk); cap_pin = 1'b1;
    wait_flag(n);
    chk("R2 filtered latency", n, 8);
    chk("R4 captured count filtered", cap_reg, count_val);
    @(negedge clk); cap_pin = 1'b0;
    idle(12);
    clr_flag();

    // R1 glitch rejection and acceptance
    @(negedge clk); cap_pin = 1'b1;
    idle(3); cap_pin = 1'b0;
    idle(14);
    chk("R1 three-cycle glitch ignored", cap_flag, 0);
    @(negedge clk); cap_pin = 1'b1;
    idle(4); cap_pin = 1'b0;
    idle(14);
    chk("R1 four-cycle pulse accepted", cap_flag, 1);
    clr_flag();

    // R3 falling mode
    wr_ctl(8'h00);
    @(negedge clk); cap_pin = 1'b1;
    idle(6);
    chk("R3 rising ignored in falling mode", cap_flag, 0);
    @(negedge clk); cap_pin = 1'b0;
    wait_flag(n);
    chk("R3 falling captured", n, 4);

    // R6 interrupt gating
    chk("R6 irq off while disabled", cap_irq, 0);
    wr_ctl(8'h04);
    chk("R6 irq with flag and enable", cap_irq, 1);
    clr_flag();
    chk("R6 irq drops with flag", cap_irq, 0);

    // R5 collision: flag set, clear coincides with new capture
    wr_ctl(8'h02);
    @(negedge clk); cap_pin = 1'b1;
    wait_flag(n);
    @(negedge clk); cap_pin = 1'b0;
    idle(6);
    @(negedge clk); cap_pin = 1'b1;
    idle(3);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R5 set wins over clear", cap_flag, 1);
    chk("R4 count on collision", cap_reg, count_val);
    clr_flag();

    // R7 capture disabled while capture register is TOP
    n = cap_reg;
    top_is_cap = 1'b1;
    @(negedge clk); cap_pin = 1'b0;
    idle(6);
    @(negedge clk); cap_pin = 1'b1;
    idle(6);
    chk("R7 no flag while disabled", cap_flag, 0);
    chk("R7 cap_reg held", cap_reg, n);
    top_is_cap = 1'b0;
    idle(3);

    // R9 polarity flips on steady pin
    wr_ctl(8'h00); wr_ctl(8'h02); wr_ctl(8'h00); wr_ctl(8'h06);
    idle(6);
    chk("R9 no capture on polarity change", cap_flag, 0);
    @(negedge clk); cap_pin = 1'b0;
    wr_ctl(8'h01); wr_ctl(8'h03);
    idle(10);
    chk("R9 filtered polarity flip no capture", cap_flag, 0);

    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule